// File: doc/BRIEF.md
# Per-CPU Timer Interrupt Control Register

This block is the control and status register of one processor on a multiprocessor board. It decodes a simple register bus into two windows. The first holds a 32-bit control/status word. The second holds a one-byte interrupt vector. The block drives a single timer interrupt line, which follows a pending flag. A periodic tick strobe arrives from a clock divider elsewhere on the chip. While the enable bit is set, each tick raises the pending flag and the interrupt line.

Software clears the interrupt by writing the control word. The write clears the flag whatever value it carries. The lowest nibble of the control word never holds written data; it always shows the identity of the processor making the access. One status bit is scrambled on each read of the control word. It is XORed with the output of a 16-bit linear feedback shift register, and that register moves one step on every such read. The vector byte is plain storage. Software places codes there such as 0xFC (transmit), 0xF8 (receive) or 0x80 (inter-processor).

Reads are combinational while the request is held. Writes and register updates take effect on the rising clock edge. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `cpu_timer_csr`

## Requirements
- R1: After reset the interrupt output is 0 and the vector byte reads 0. The control word reads 0 except for bits [3:0], which show the processor ID, and bit 16, which shows the scrambling bit.
- R2: Bits [3:0] of every control-word read equal `cpu_id_i` in the same cycle, whatever was written to those bits.
- R3: A control-word write (address 0x0) stores write-data bits [31:4]. Bit 29 is stored as 0. Every other stored bit reads back unchanged, except bit 16.
- R4: A `tick_i` strobe while stored bit 15 (timer enable) is 1 sets bit 29 (pending), and `irq_o` is 1 from the next cycle on. A tick while bit 15 is 0 changes nothing.
- R5: Any control-word write clears bit 29 and drops `irq_o` in the next cycle, even when the written data has bit 29 set.
- R6: When a tick and a control-word write fall in the same cycle, the tick is judged against the enable value held before the write. If that enable was 1, pending ends up set.
- R7: Read bit 16 equals stored bit 16 XOR bit 0 of a 16-bit LFSR. The LFSR resets to 0xACE1. On each control-word read it steps to {s[14:0], s[15]^s[13]^s[12]^s[10]}, and the value before the step is the one used.
- R8: The LFSR steps only on control-word reads. Writes, vector accesses and accesses to other addresses leave it unchanged.
- R9: Any address from 0x3000_0000 to 0x3000_00FF reaches the vector register. A write stores data bits [7:0], and a read returns the last byte written with bits [31:8] as 0. Vector accesses do not touch the control word or `irq_o`.
- R10: Any other address reads as 0, and writes to it are ignored.
- R11: Once set, pending and `irq_o` stay at 1 through further ticks and idle cycles until a control-word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte offset from block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is requested |
| cpu_id_i | input | 4 | ID of the accessing processor |
| tick_i | input | 1 | One-cycle periodic timer strobe |
| irq_o | output | 1 | Timer interrupt line |

## Verification
The bench drives a write and a tick in the same cycle. A design that checked the newly written enable, or let the write win, would lose that interrupt or raise a spurious one. It writes data with bit 29 set to check that the acknowledge cannot be bypassed. It also writes ones into the ID nibble, where a design that stored them would show them on reads. The bench predicts the scrambled bit 16 from its own LFSR model across reads that come between vector accesses and accesses to other addresses. A design that stepped the LFSR on the wrong accesses would then return the wrong bit 16.

// File: rtl/tcsr_pkg.sv
package tcsr_pkg;
  localparam int DATA_W    = 32;
  localparam int EN_BIT    = 15;
  localparam int NOISE_BIT = 16;
  localparam int PEND_BIT  = 29;
endpackage

// File: rtl/tcsr_rst_sync.sv
module tcsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tcsr_lfsr.sv
module tcsr_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   TAPS = 16'hB400,
  parameter logic [W-1:0]   SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state_q
);
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= SEED;
    else if (step) state_q <= state_d;
  end
endmodule

// File: rtl/tcsr_ctl.sv
module tcsr_ctl
  import tcsr_pkg::*;
#(
  parameter int ID_W = 4,
  localparam int HI_W = DATA_W - ID_W,
  localparam int EN_IX = EN_BIT - ID_W,
  localparam int PEND_IX = PEND_BIT - ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [HI_W-1:0] wdata_hi,
  input  logic            tick,
  output logic [HI_W-1:0] hi_q,
  output logic            tmr_en,
  output logic            pend
);
  logic [HI_W-1:0] hi_d;
  logic            upd;

  assign tmr_en = hi_q[EN_IX];
  assign pend   = hi_q[PEND_IX];
  assign upd    = wr | tick;

  always_comb begin
    hi_d = hi_q;
    if (wr) begin
      hi_d          = wdata_hi;
      hi_d[PEND_IX] = 1'b0;
    end
    if (tick && tmr_en) hi_d[PEND_IX] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_q <= '0;
    else if (upd) hi_q <= hi_d;
  end
endmodule

// File: rtl/tcsr_vec_reg.sv
module tcsr_vec_reg #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] vec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vec_q <= '0;
    else if (wr) vec_q <= wdata;
  end
endmodule

// File: rtl/cpu_timer_csr.sv
module cpu_timer_csr
  import tcsr_pkg::*;
#(
  parameter int                 ID_W          = 4,
  parameter int                 VEC_W         = 8,
  parameter int                 LFSR_W        = 16,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS     = 16'hB400,
  parameter logic [LFSR_W-1:0]  LFSR_SEED     = 16'hACE1,
  parameter logic [DATA_W-1:0]  CSR_ADDR      = 32'h0000_0000,
  parameter logic [DATA_W-1:0]  VEC_BASE      = 32'h3000_0000,
  parameter int                 VEC_SPAN_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ID_W-1:0]   cpu_id_i,
  input  logic              tick_i,
  output logic              irq_o
);
  localparam int HI_W = DATA_W - ID_W;

  logic              rst_sync_n;
  logic              csr_hit, vec_hit;
  logic              csr_rd, csr_wr, vec_rd, vec_wr;
  logic [HI_W-1:0]   ctl_hi;
  logic              tmr_en, pend;
  logic [VEC_W-1:0]  vec_q;
  logic [LFSR_W-1:0] lfsr_q;

  tcsr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign csr_hit = (bus_addr == CSR_ADDR);
  assign vec_hit = ((bus_addr >> VEC_SPAN_LOG2) == (VEC_BASE >> VEC_SPAN_LOG2));
  assign csr_rd  = bus_req & ~bus_we & csr_hit;
  assign csr_wr  = bus_req &  bus_we & csr_hit;
  assign vec_rd  = bus_req & ~bus_we & vec_hit;
  assign vec_wr  = bus_req &  bus_we & vec_hit;

  tcsr_ctl #(.ID_W(ID_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .wr(csr_wr),
    .wdata_hi(bus_wdata[DATA_W-1:ID_W]), .tick(tick_i),
    .hi_q(ctl_hi), .tmr_en(tmr_en), .pend(pend)
  );

  tcsr_vec_reg #(.VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst_n(rst_sync_n), .wr(vec_wr),
    .wdata(bus_wdata[VEC_W-1:0]), .vec_q(vec_q)
  );

  tcsr_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_sync_n), .step(csr_rd), .state_q(lfsr_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (csr_rd) begin
      bus_rdata            = {ctl_hi, cpu_id_i};
      bus_rdata[NOISE_BIT] = ctl_hi[NOISE_BIT-ID_W] ^ lfsr_q[0];
    end else if (vec_rd) begin
      bus_rdata = {{(DATA_W-VEC_W){1'b0}}, vec_q};
    end
  end

  assign irq_o = pend;
endmodule

// File: rtl/tcsr_chk.sv
module tcsr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic        csr_hit,
  input logic        vec_hit,
  input logic        csr_rd,
  input logic        csr_wr,
  input logic        tick_i,
  input logic        tmr_en,
  input logic        irq_o,
  input logic [3:0]  cpu_id_i,
  input logic [31:0] bus_rdata,
  input logic [15:0] lfsr_q
);
  AST_TICK_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n) tick_i && tmr_en |=> irq_o); // R4
  AST_WRITE_ACKS: assert property (@(posedge clk) disable iff (!rst_n) csr_wr && !(tick_i && tmr_en) |=> !irq_o); // R5
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) irq_o && !csr_wr |=> irq_o); // R11
  AST_ID_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n) csr_rd |-> bus_rdata[3:0] == cpu_id_i); // R2
  AST_LFSR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !csr_rd |=> $stable(lfsr_q)); // R8
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != 16'h0); // R7
  AST_VEC_UPPER: assert property (@(posedge clk) disable iff (!rst_n) bus_req && !bus_we && vec_hit |-> bus_rdata[31:8] == 24'h0); // R9
  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bus_req && !bus_we && !csr_hit && !vec_hit |-> bus_rdata == 32'h0); // R10
endmodule

bind cpu_timer_csr tcsr_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_req(bus_req), .bus_we(bus_we),
  .csr_hit(csr_hit), .vec_hit(vec_hit), .csr_rd(csr_rd), .csr_wr(csr_wr),
  .tick_i(tick_i), .tmr_en(tmr_en), .irq_o(irq_o), .cpu_id_i(cpu_id_i),
  .bus_rdata(bus_rdata), .lfsr_q(lfsr_q)
);

// File: tb/test_cpu_timer_csr.sv
`timescale 1ns/1ps
module test_cpu_timer_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  cpu_id_i;
  logic        tick_i;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] m_hi;
  logic [7:0]  m_vec;
  logic [15:0] m_lfsr;

  always #10 clk = ~clk;

  cpu_timer_csr i_cpu_timer_csr (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_id_i(cpu_id_i), .tick_i(tick_i), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    if (bus_req && !bus_we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  // expected control-word read; steps the model LFSR (R7)
  task automatic rd_csr(input string t);
    logic [31:0] e;
    e = m_hi | {28'h0, cpu_id_i};
    e[16] = e[16] ^ m_lfsr[0];
    m_lfsr = lfsr_step(m_lfsr);
    rd(32'h0, e, t);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit tk);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_i = tk;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0; tick_i = 1'b0;
    if (a == 32'h0) begin
      bit old_en;
      old_en = m_hi[15];
      m_hi = {d[31:4], 4'h0};
      m_hi[29] = 1'b0;
      if (tk && old_en) m_hi[29] = 1'b1;
    end else if (a[31:8] == 24'h300000) begin
      m_vec = d[7:0];
    end
  endtask

  task automatic tick();
    @(posedge clk); #1; tick_i = 1'b1;
    @(posedge clk); #1; tick_i = 1'b0;
    if (m_hi[15]) m_hi[29] = 1'b1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq_o=%b expected=%b", t, irq_o, e);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; cpu_id_i = 4'h3; tick_i = 1'b0;
    m_hi = '0; m_vec = '0; m_lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    chk_irq(1'b0, "R1 irq after reset");
    rd_csr("R1 csr after reset");
    rd(32'h3000_0000, 32'h0, "R1 vector after reset");

    // ID nibble
    wr(32'h0, 32'h0000_000F, 1'b0);
    rd_csr("R2 written nibble ignored");
    cpu_id_i = 4'hA;
    rd_csr("R2 id follows input");

    // storage without enable, tick ignored
    wr(32'h0, 32'h5A5A_7FF0, 1'b0);
    rd_csr("R3 stored pattern");
    wr(32'h0, 32'hA5A5_0000, 1'b0);
    rd_csr("R3 stored inverse pattern");
    tick();
    chk_irq(1'b0, "R4 tick while disabled");
    rd_csr("R4 no pending while disabled");

    // enable, tick raises pending
    wr(32'h0, 32'h0001_8000, 1'b0);
    chk_irq(1'b0, "R4 enable alone no irq");
    tick();
    chk_irq(1'b1, "R4 tick raises irq");
    rd_csr("R4 pending visible");
    tick();
    chk_irq(1'b1, "R11 second tick holds");
    repeat (5) @(posedge clk);
    chk_irq(1'b1, "R11 idle holds");

    // acknowledge even with bit 29 written
    wr(32'h0, 32'h2000_8000, 1'b0);
    chk_irq(1'b0, "R5 write acks");
    rd_csr("R5 pending cleared");

    // tick coincident with write
    wr(32'h0, 32'h0000_8000, 1'b1);
    chk_irq(1'b1, "R6 tick with write while enabled");
    wr(32'h0, 32'h0000_0000, 1'b1);
    chk_irq(1'b1, "R6 old enable judged");
    rd_csr("R6 pending after disabling write");
    wr(32'h0, 32'h0000_0000, 1'b0);
    chk_irq(1'b0, "R5 plain ack");
    wr(32'h0, 32'h0000_8000, 1'b0);
    wr(32'h0, 32'h0000_0000, 1'b1);
    chk_irq(1'b1, "R6 tick with disabling write");
    wr(32'h0, 32'h0000_0000, 1'b0);
    wr(32'h0, 32'h0000_0000, 1'b1);
    chk_irq(1'b0, "R6 tick with write while disabled");

    // scrambled bit sequence
    wr(32'h0, 32'h0001_0000, 1'b0);
    for (int i = 0; i < 6; i++) rd_csr("R7 bit16 set sequence");
    wr(32'h0, 32'h0000_0000, 1'b0);
    for (int i = 0; i < 6; i++) rd_csr("R7 bit16 clear sequence");

    // vector window
    wr(32'h3000_0000, 32'h0000_00FC, 1'b0);
    rd(32'h3000_0010, 32'h0000_00FC, "R9 vector transmit code");
    wr(32'h3000_00FF, 32'hFFFF_01F8, 1'b0);
    rd(32'h3000_0000, 32'h0000_00F8, "R9 vector receive code");
    wr(32'h3000_0044, 32'h0000_0080, 1'b0);
    rd(32'h3000_0080, 32'h0000_0080, "R9 vector ipi code");
    chk_irq(1'b0, "R9 vector write leaves irq");
    rd_csr("R8 csr after vector accesses");

    // other addresses
    wr(32'h0000_0004, 32'hFFFF_FFFF, 1'b0);
    rd(32'h0000_0004, 32'h0, "R10 other offset reads zero");
    wr(32'h3000_0100, 32'hFFFF_FFFF, 1'b0);
    rd(32'h3000_0100, 32'h0, "R10 past vector window");
    rd_csr("R10 csr untouched");
    rd(32'h3000_0000, 32'h0000_0080, "R10 vector untouched");
    chk_irq(1'b0, "R10 irq untouched");
    rd_csr("R8 lfsr after other accesses");

    repeat (2) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule